// File: doc/BRIEF.md
# Hierarchical Interrupt Status Aggregator

This block collects interrupt causes from four functional units: a transmit cell processor, a receive cell processor, a transmit cell-bus interface and a receive cell-bus interface. Each unit's event inputs are one-cycle pulses. The block latches them into a cause register for that unit. Enable registers mask them, and the enabled causes are folded into one pending bit per unit. The four pending bits form a read-only summary register, and one active-high interrupt line is the OR of those bits.

A local microprocessor reaches the block over a simple synchronous register bus. The service routine reads the summary register to find which unit is asking for service. It then reads that unit's own status register. That second read returns the latched causes and clears them, and the matching summary bit clears with them. Reading the summary register alone never clears anything. The single-cause transmit cell processor follows the same rule: its status register must still be read before its request goes away.

A two-state bus controller handles reads. It has the states `BUS_IDLE` and `BUS_RSP`. A read strobe in either state moves the controller to `BUS_RSP` and captures the selected register. In any cycle with no read strobe, the controller returns to `BUS_IDLE`. Read data is driven only while the controller is in `BUS_RSP`, which is the cycle after the strobe. In `BUS_IDLE` the read data is zero.

Top module: `irq_status_agg`

## Requirements
- R1: After reset, all cause registers and enable registers are zero, `irq` is 0 and `rd_data` is 0.
- R2: An event pulse sets its cause bit on the next clock edge, and the bit stays set until its unit's status register is read.
- R3: The summary register is at 05h. Bit 3 is the transmit cell processor, bit 2 the receive cell processor, bit 1 the transmit cell-bus interface and bit 0 the receive cell-bus interface. Each bit is the OR of that unit's latched causes ANDed with their enables. Bits 7:4 read as 0.
- R4: The status registers are at 72h (transmit cell processor, cause in bit 0), 61h (receive cell processor, bits 3:0), 80h (transmit cell-bus, bits 2:0) and 7Dh (receive cell-bus, bits 2:0). A read returns the latched causes and clears them, which also clears the unit's summary bit.
- R5: Reading the summary register clears no cause and no summary bit.
- R6: When an event arrives in the same cycle as the clearing read of its register, the read returns the value held before that cycle, and the event's bit is set afterwards.
- R7: The enable registers are at 73h (bit 0), 62h (bits 3:0), 81h (bits 2:0) and 7Eh (bits 2:0). They can be written and read back. A disabled cause still latches and can be read in its status register, but it does not reach the summary register.
- R8: `irq` is active-high and is 1 exactly when some summary bit is 1.
- R9: `rd_data` carries the register value in the cycle after the read strobe and is 0 in every other cycle. Reads of unmapped addresses return 0 and change no state.
- R10: Writes to the summary register or to a status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 4 | Write data (enable bits) |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| evt_txcp | input | 1 | Transmit cell processor integrity-error pulse |
| evt_rxcp | input | 4 | Receive cell processor cause pulses |
| evt_txcb | input | 3 | Transmit cell-bus interface cause pulses |
| evt_rxcb | input | 3 | Receive cell-bus interface cause pulses |
| irq | output | 1 | Interrupt request, active-high |

## Verification
Suppose a cause bit fails to latch, clears too early or clears on the wrong read. The port would then show the summary bit or `irq` disagreeing with the pending work. This shows up one cycle after the pulse, or in the data returned by the next read. Suppose instead the bus controller is stuck in the wrong state. Then `rd_data` would be nonzero in a cycle with no read, or zero in the cycle after one, and the error appears on the very next bus cycle. The directed scenarios read the summary register both before and after each status read. That catches a clear landing on the wrong unit or on the wrong register.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int N_SRC    = 4;
    localparam int SUM_TXCP = 3;
    localparam int SUM_RXCP = 2;
    localparam int SUM_TXCB = 1;
    localparam int SUM_RXCB = 0;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RSP  = 1'b1
    } bus_state_t;
endpackage

// File: rtl/irq_cause_latch.sv
module irq_cause_latch #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr,
    input  logic         en_we,
    input  logic [N-1:0] en_wdata,
    output logic [N-1:0] lat,
    output logic [N-1:0] en,
    output logic         pend
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat <= '0;
            en  <= '0;
        end else begin
            lat <= (lat & ~{N{clr}}) | evt;
            if (en_we)
                en <= en_wdata;
        end
    end

    assign pend = |(lat & en);
endmodule

// File: rtl/irq_bus_fsm.sv
module irq_bus_fsm
    import irq_agg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] sel_data,
    output logic [DATA_W-1:0] rd_data
);
    bus_state_t        state, state_nx;
    logic [DATA_W-1:0] cap;

    always_comb begin
        state_nx = state;
        unique case (state)
            BUS_IDLE: if (rd_en) state_nx = BUS_RSP;
            BUS_RSP:  state_nx = rd_en ? BUS_RSP : BUS_IDLE;
            default:  state_nx = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= BUS_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     cap <= '0;
        else if (rd_en) cap <= sel_data;
    end

    always_comb begin
        unique case (state)
            BUS_RSP: rd_data = cap;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_agg_pkg::*;
#(
    parameter int              ADDR_W       = 8,
    parameter int              DATA_W       = 8,
    parameter int              N_RXCP       = 4,
    parameter int              N_CB         = 3,
    parameter logic [ADDR_W-1:0] SUMMARY_ADDR = 8'h05,
    parameter logic [ADDR_W-1:0] TXCP_ST    = 8'h72,
    parameter logic [ADDR_W-1:0] RXCP_ST    = 8'h61,
    parameter logic [ADDR_W-1:0] TXCB_ST    = 8'h80,
    parameter logic [ADDR_W-1:0] RXCB_ST    = 8'h7D,
    parameter logic [ADDR_W-1:0] TXCP_EN    = 8'h73,
    parameter logic [ADDR_W-1:0] RXCP_EN    = 8'h62,
    parameter logic [ADDR_W-1:0] TXCB_EN    = 8'h81,
    parameter logic [ADDR_W-1:0] RXCB_EN    = 8'h7E,
    localparam int             EN_W         = (N_RXCP > N_CB) ? N_RXCP : N_CB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [EN_W-1:0]   wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              evt_txcp,
    input  logic [N_RXCP-1:0] evt_rxcp,
    input  logic [N_CB-1:0]   evt_txcb,
    input  logic [N_CB-1:0]   evt_rxcb,
    output logic              irq
);
    logic [0:0]        lat_txcp, en_txcp;
    logic [N_RXCP-1:0] lat_rxcp, en_rxcp;
    logic [N_CB-1:0]   lat_txcb, en_txcb, lat_rxcb, en_rxcb;
    logic              clr_txcp, clr_rxcp, clr_txcb, clr_rxcb;
    logic [N_SRC-1:0]  summary;
    logic [DATA_W-1:0] sel_data;

    assign clr_txcp = rd_en && (addr == TXCP_ST);
    assign clr_rxcp = rd_en && (addr == RXCP_ST);
    assign clr_txcb = rd_en && (addr == TXCB_ST);
    assign clr_rxcb = rd_en && (addr == RXCB_ST);

    irq_cause_latch #(.N(1)) u_txcp (
        .clk(clk), .rst_n(rst_n), .evt(evt_txcp), .clr(clr_txcp),
        .en_we(wr_en && (addr == TXCP_EN)), .en_wdata(wr_data[0:0]),
        .lat(lat_txcp), .en(en_txcp), .pend(summary[SUM_TXCP])
    );

    irq_cause_latch #(.N(N_RXCP)) u_rxcp (
        .clk(clk), .rst_n(rst_n), .evt(evt_rxcp), .clr(clr_rxcp),
        .en_we(wr_en && (addr == RXCP_EN)), .en_wdata(wr_data[N_RXCP-1:0]),
        .lat(lat_rxcp), .en(en_rxcp), .pend(summary[SUM_RXCP])
    );

    irq_cause_latch #(.N(N_CB)) u_txcb (
        .clk(clk), .rst_n(rst_n), .evt(evt_txcb), .clr(clr_txcb),
        .en_we(wr_en && (addr == TXCB_EN)), .en_wdata(wr_data[N_CB-1:0]),
        .lat(lat_txcb), .en(en_txcb), .pend(summary[SUM_TXCB])
    );

    irq_cause_latch #(.N(N_CB)) u_rxcb (
        .clk(clk), .rst_n(rst_n), .evt(evt_rxcb), .clr(clr_rxcb),
        .en_we(wr_en && (addr == RXCB_EN)), .en_wdata(wr_data[N_CB-1:0]),
        .lat(lat_rxcb), .en(en_rxcb), .pend(summary[SUM_RXCB])
    );

    always_comb begin
        sel_data = '0;
        if      (addr == SUMMARY_ADDR) sel_data[N_SRC-1:0]  = summary;
        else if (addr == TXCP_ST)      sel_data[0:0]        = lat_txcp;
        else if (addr == RXCP_ST)      sel_data[N_RXCP-1:0] = lat_rxcp;
        else if (addr == TXCB_ST)      sel_data[N_CB-1:0]   = lat_txcb;
        else if (addr == RXCB_ST)      sel_data[N_CB-1:0]   = lat_rxcb;
        else if (addr == TXCP_EN)      sel_data[0:0]        = en_txcp;
        else if (addr == RXCP_EN)      sel_data[N_RXCP-1:0] = en_rxcp;
        else if (addr == TXCB_EN)      sel_data[N_CB-1:0]   = en_txcb;
        else if (addr == RXCB_EN)      sel_data[N_CB-1:0]   = en_rxcb;
    end

    irq_bus_fsm #(.DATA_W(DATA_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en),
        .sel_data(sel_data), .rd_data(rd_data)
    );

    assign irq = |summary;
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
    parameter int                ADDR_W       = 8,
    parameter int                DATA_W       = 8,
    parameter int                N_RXCP       = 4,
    parameter logic [ADDR_W-1:0] SUMMARY_ADDR = 8'h05
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [3:0]        summary,
    input logic [0:0]        lat_txcp,
    input logic              clr_txcp,
    input logic              evt_txcp,
    input logic [N_RXCP-1:0] lat_rxcp,
    input logic              clr_rxcp,
    input logic [N_RXCP-1:0] evt_rxcp
);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_txcp[0] && !clr_txcp) |=> lat_txcp[0]);

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rxcp && (evt_rxcp == '0)) |=> (lat_rxcp == '0));

    assert_summary_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == SUMMARY_ADDR)) |=> (($past(summary) & ~summary) == 4'b0000));

    assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_txcp |=> lat_txcp[0]);

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));
endmodule

bind irq_status_agg irq_agg_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_RXCP(N_RXCP), .SUMMARY_ADDR(SUMMARY_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rd_data(rd_data),
    .summary(summary), .lat_txcp(lat_txcp), .clr_txcp(clr_txcp), .evt_txcp(evt_txcp),
    .lat_rxcp(lat_rxcp), .clr_rxcp(clr_rxcp), .evt_rxcp(evt_rxcp)
);

// File: tb/tb_irq_status_agg.sv
module tb_irq_status_agg;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] addr = 0;
    logic       rd_en = 0, wr_en = 0;
    logic [3:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       evt_txcp = 0;
    logic [3:0] evt_rxcp = 0;
    logic [2:0] evt_txcb = 0, evt_rxcb = 0;
    logic       irq;
    int         n_run = 0, n_fail = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    irq_status_agg dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .evt_txcp(evt_txcp),
        .evt_rxcp(evt_rxcp), .evt_txcb(evt_txcb), .evt_rxcb(evt_rxcb), .irq(irq)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0; addr = 8'h00;
        d = rd_data;
    endtask

    task automatic wr(logic [7:0] a, logic [3:0] d);
        @(negedge clk); wr_en = 1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 0; addr = 8'h00; wr_data = 0;
    endtask

    task automatic pulse(logic t, logic [3:0] r, logic [2:0] tc, logic [2:0] rc);
        @(negedge clk); evt_txcp = t; evt_rxcp = r; evt_txcb = tc; evt_rxcb = rc;
        @(negedge clk); evt_txcp = 0; evt_rxcp = 0; evt_txcb = 0; evt_rxcb = 0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 rd_data", rd_data, 8'h00);
        rd(8'h05, d); chk("R1 summary", d, 8'h00);
        rd(8'h62, d); chk("R1 enable", d, 8'h00);
        rd(8'h61, d); chk("R1 cause", d, 8'h00);
    endtask

    task automatic t_enables();
        logic [7:0] d;
        wr(8'h73, 4'h1); wr(8'h62, 4'hF); wr(8'h81, 4'h7); wr(8'h7E, 4'h7);
        rd(8'h62, d); chk("R7 readback 62h", d, 8'h0F);
        rd(8'h7E, d); chk("R7 readback 7Eh", d, 8'h07);
    endtask

    task automatic t_hold_and_clear();
        logic [7:0] d;
        pulse(0, 0, 0, 3'b010);
        repeat (3) @(negedge clk);
        chk("R2 irq held", {7'b0, irq}, 8'h01);
        rd(8'h05, d); chk("R3 summary rxcb", d, 8'h01);
        rd(8'h05, d); chk("R5 summary not cleared", d, 8'h01);
        rd(8'h7D, d); chk("R4 rxcb causes", d, 8'h02);
        rd(8'h05, d); chk("R4 summary cleared", d, 8'h00);
        chk("R8 irq low", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_order();
        logic [7:0] d;
        pulse(1, 0, 0, 0);
        rd(8'h05, d); chk("R3 txcp bit3", d, 8'h08);
        pulse(0, 4'b1000, 0, 0);
        rd(8'h05, d); chk("R3 rxcp bit2", d, 8'h0C);
        pulse(0, 0, 3'b100, 0);
        rd(8'h05, d); chk("R3 txcb bit1", d, 8'h0E);
        chk("R8 irq high", {7'b0, irq}, 8'h01);
        rd(8'h72, d); chk("R4 txcp cause", d, 8'h01);
        rd(8'h05, d); chk("R4 only txcp cleared", d, 8'h06);
        rd(8'h61, d); chk("R4 rxcp causes", d, 8'h08);
        rd(8'h80, d); chk("R4 txcb causes", d, 8'h04);
        chk("R8 irq cleared", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        wr(8'h62, 4'b1110);
        pulse(0, 4'b0001, 0, 0);
        chk("R7 masked irq", {7'b0, irq}, 8'h00);
        rd(8'h05, d); chk("R7 masked summary", d, 8'h00);
        wr(8'h62, 4'b0001);
        chk("R7 unmasked irq", {7'b0, irq}, 8'h01);
        rd(8'h61, d); chk("R7 masked cause latched", d, 8'h01);
        wr(8'h62, 4'hF);
    endtask

    task automatic t_same_cycle();
        logic [7:0] d;
        pulse(0, 4'b0001, 0, 0);
        @(negedge clk); rd_en = 1; addr = 8'h61; evt_rxcp = 4'b0010;
        @(negedge clk); rd_en = 0; addr = 0; evt_rxcp = 0;
        chk("R6 read returns old", rd_data, 8'h01);
        rd(8'h61, d); chk("R6 new event kept", d, 8'h02);
        @(negedge clk); rd_en = 1; addr = 8'h72; evt_txcp = 1;
        @(negedge clk); rd_en = 0; addr = 0; evt_txcp = 0;
        chk("R6 txcp kept irq", {7'b0, irq}, 8'h01);
        rd(8'h72, d); chk("R6 txcp cause", d, 8'h01);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        pulse(0, 0, 0, 3'b101);
        rd(8'h40, d); chk("R9 unmapped zero", d, 8'h00);
        @(negedge clk);
        chk("R9 idle zero", rd_data, 8'h00);
        rd(8'h05, d); chk("R9 no side effect", d, 8'h01);
        wr(8'h7D, 4'h0); wr(8'h05, 4'h0);
        rd(8'h7D, d); chk("R10 write ignored", d, 8'h05);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_enables();
        t_hold_and_clear();
        t_order();
        t_mask();
        t_same_cycle();
        t_unmapped();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule